// File: doc/BRIEF.md
# Centered One-Cycle DFT Phasor Estimator

This block turns a stream of signed fixed-point waveform samples, taken at N samples per nominal power-system cycle, into a complex RMS phasor. Each estimate covers exactly one nominal cycle, and that cycle is centered on a reporting time mark. The samples are half a sampling interval away from the mark on either side, and the complex exponential carries the same half-step shift. As a result, a cosine at nominal frequency comes out with no gain error and no phase error. The phasor is referenced to a cosine and scaled to RMS rather than peak.

Upstream logic asserts the report strobe once the sample that closes the window has arrived, so the window holds N/2 samples on each side of the time mark. Samples are kept in a circular buffer. The strobe starts a serial multiply-accumulate over the N taps using an internal table of cosine and sine coefficients. Each accepted strobe produces one output-valid pulse carrying 16-bit real and imaginary parts. A strobe that arrives while an estimate is still in progress is dropped and flagged. Frequency tracking, off-nominal correction, polar conversion and filter-delay correction belong to other blocks.

Top module: `phz_centered_dft`

## Requirements
- R1: While reset is high, and in the first cycle after it, `phasor_valid` and `mark_overrun` are low and both phasor outputs read zero. The sample buffer is cleared to zero.
- R2: A report mark accepted at clock edge E gives exactly one `phasor_valid` pulse, visible after edge E+N+1 and lasting one cycle.
- R3: Full-scale inputs (−32768 or +32767 on every tap, in any sign pattern) never overflow the accumulators. A window whose signs follow the cosine table gives the exact R6 result, which is a positive real part above 29000 for N=16.
- R4: The window holds the N most recently accepted samples, including one accepted in the same cycle as the mark. Window position m = 0 is the oldest sample and m = N−1 is the newest.
- R5: With θm = 2π(m − N/2 + ½)/N, Cm = round(32767·cos θm) and Sm = round(32767·sin θm), both rounded half away from zero: the accumulated real sum is Σ x_m·Cm and the accumulated imaginary sum is −Σ x_m·Sm.
- R6: Each sum A is scaled as (A·K + 2^(SH−1)) >>> SH, where KS = OW + log2(N), K = round(√2·2^KS/N) and SH = 15 + KS. The result is saturated to the signed OW-bit range.
- R7: For a nominal-frequency input x = round(a·cos(θm + φ)), the output is within 4 LSB of (a/√2)·cos φ on the real part and (a/√2)·sin φ on the imaginary part.
- R8: A mark that arrives while the block is busy (the N+1 cycles after an accepted mark) raises `mark_overrun` for one cycle after that edge. It produces no extra phasor and does not change the estimate in progress.
- R9: Samples accepted while an estimate is in progress, at any rate up to one per clock, do not change that estimate.
- R10: A mark that arrives N+2 edges after the previous accepted mark is accepted.
- R11: `phasor_valid` never rises unless a mark was accepted.
- R12: `phasor_re` and `phasor_im` keep their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new sample is present on `sample_in` |
| sample_in | input | SW | Signed waveform sample |
| report_mark | input | 1 | Window complete; start an estimate |
| phasor_valid | output | 1 | One-cycle pulse: a new phasor is on the outputs |
| phasor_re | output | OW | Real part of the RMS phasor |
| phasor_im | output | OW | Imaginary part of the RMS phasor |
| mark_overrun | output | 1 | Pulse: a mark was dropped because the block was busy |

## Verification
The bound checker watches the control behaviour on every cycle:
- the exact N+1 latency and single-cycle width of the valid pulse;
- the absence of valid pulses without an accepted mark;
- the overrun flag for marks that arrive while busy;
- the outputs holding steady between results.

The numeric content cannot be expressed as a property, so only the bench scenarios show it. This covers the centered coefficient table, the window alignment including the sample taken with the mark, rounding and saturation, the absence of accumulator overflow on full-scale windows, independence from samples streaming in during a computation, and the gain and phase accuracy at nominal frequency.

// File: rtl/phz_pkg.sv
package phz_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ACC   = 2'd1,
      PH_SCALE = 2'd2
   } phz_state_e;

   localparam real PHZ_PI = 3.14159265358979323846;

   // round half away from zero
   function automatic int phz_round(input real v);
      return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
   endfunction

   // centered tap angle for window position m of n, scaled to cw-bit fraction
   function automatic int phz_coef(input int m, input int n, input bit use_sin, input int cw);
      real th;
      real full;
      th   = 2.0 * PHZ_PI * (real'(m) - real'(n) / 2.0 + 0.5) / real'(n);
      full = real'((1 << (cw - 1)) - 1);
      return phz_round((use_sin ? $sin(th) : $cos(th)) * full);
   endfunction

   // RMS gain sqrt(2)/n expressed with ks fractional bits
   function automatic int phz_scale_k(input int n, input int ks);
      return phz_round($sqrt(2.0) * (2.0 ** ks) / real'(n));
   endfunction

endpackage

// File: rtl/phz_coef_rom.sv
module phz_coef_rom #(
   parameter int N  = 16,
   parameter int CW = 16,
   localparam int AW = $clog2(N)
) (
   input  logic [AW-1:0]        tap,
   output logic signed [CW-1:0] cos_o,
   output logic signed [CW-1:0] sin_o
);

   logic signed [CW-1:0] cos_tab [N];
   logic signed [CW-1:0] sin_tab [N];

   for (genvar g = 0; g < N; g++) begin : g_tap
      localparam int CV = phz_pkg::phz_coef(g, N, 1'b0, CW);
      localparam int SV = phz_pkg::phz_coef(g, N, 1'b1, CW);
      assign cos_tab[g] = CW'(CV);
      assign sin_tab[g] = CW'(SV);
   end

   assign cos_o = cos_tab[tap];
   assign sin_o = sin_tab[tap];

endmodule

// File: rtl/phz_sample_buf.sv
module phz_sample_buf #(
   parameter int N  = 16,
   parameter int SW = 16,
   localparam int AW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic signed [SW-1:0] wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic signed [SW-1:0] rd_data,
   output logic [AW-1:0]        wptr
);

   logic signed [SW-1:0] mem [N];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
         wptr <= '0;
      end else if (wr_en) begin
         mem[wptr] <= wr_data;
         wptr      <= (wptr == AW'(N - 1)) ? '0 : wptr + 1'b1;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/phz_mac.sv
module phz_mac #(
   parameter int SW    = 16,
   parameter int CW    = 16,
   parameter int ACC_W = 36
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    en,
   input  logic signed [SW-1:0]    x,
   input  logic signed [CW-1:0]    c,
   input  logic signed [CW-1:0]    s,
   output logic signed [ACC_W-1:0] acc_re,
   output logic signed [ACC_W-1:0] acc_im
);

   localparam int PW = SW + CW;

   logic signed [PW-1:0] p_re;
   logic signed [PW-1:0] p_im;

   assign p_re = PW'(x) * PW'(c);
   assign p_im = PW'(x) * PW'(s);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (en) begin
         acc_re <= acc_re + ACC_W'(p_re);
         acc_im <= acc_im - ACC_W'(p_im);
      end
   end

endmodule

// File: rtl/phz_scale.sv
module phz_scale #(
   parameter int ACC_W    = 36,
   parameter int KW       = 19,
   parameter int K        = 92682,
   parameter int SH       = 35,
   parameter int OW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OW-1:0]    y
);

   localparam int PW = ACC_W + KW;
   localparam logic signed [PW-1:0] KC   = PW'(K);
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);
   localparam logic signed [PW-1:0] HI   = PW'((2 ** (OW - 1)) - 1);
   localparam logic signed [PW-1:0] LO   = PW'(-(2 ** (OW - 1)));

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shf;

   assign prod = PW'(acc) * KC;
   assign shf  = (prod + HALF) >>> SH;

   if (SATURATE) begin : g_sat
      assign y = (shf > HI) ? OW'(HI) : ((shf < LO) ? OW'(LO) : OW'(shf));
   end else begin : g_wrap
      assign y = OW'(shf);
   end

endmodule

// File: rtl/phz_centered_dft.sv
module phz_centered_dft #(
   parameter int N        = 16,
   parameter int SW       = 16,
   parameter int CW       = 16,
   parameter int OW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sample_valid,
   input  logic signed [SW-1:0] sample_in,
   input  logic                 report_mark,
   output logic                 phasor_valid,
   output logic signed [OW-1:0] phasor_re,
   output logic signed [OW-1:0] phasor_im,
   output logic                 mark_overrun
);

   import phz_pkg::*;

   localparam int AW    = $clog2(N);
   localparam int ACC_W = SW + CW + AW;
   localparam int KS    = OW + AW;
   localparam int KVAL  = phz_scale_k(N, KS);
   localparam int KW    = OW + 3;
   localparam int SH    = (CW - 1) + KS;

   if ((N % 2) != 0 || N < 4) begin : g_bad_n
      $error("phz_centered_dft: N must be even and at least 4");
   end
   if (OW > 30 || CW > 31 || SW > 31) begin : g_bad_w
      $error("phz_centered_dft: width parameter out of range");
   end

   phz_state_e           st;
   logic [AW-1:0]        tap;
   logic [AW-1:0]        rd_addr;
   logic [AW-1:0]        wptr;
   logic [AW-1:0]        base;
   logic signed [SW-1:0] rd_data;
   logic signed [CW-1:0] c_cos;
   logic signed [CW-1:0] c_sin;
   logic signed [ACC_W-1:0] acc_re;
   logic signed [ACC_W-1:0] acc_im;
   logic signed [OW-1:0] sc_re;
   logic signed [OW-1:0] sc_im;
   logic                 accept;

   assign accept = (st == PH_IDLE) && report_mark;
   // a sample written in the mark cycle belongs to the window, so skip past it
   assign base   = sample_valid ? ((wptr == AW'(N - 1)) ? '0 : wptr + 1'b1) : wptr;

   phz_sample_buf #(.N(N), .SW(SW)) u_buf (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (sample_valid),
      .wr_data (sample_in),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wptr    (wptr)
   );

   phz_coef_rom #(.N(N), .CW(CW)) u_rom (
      .tap   (tap),
      .cos_o (c_cos),
      .sin_o (c_sin)
   );

   phz_mac #(.SW(SW), .CW(CW), .ACC_W(ACC_W)) u_mac (
      .clk    (clk),
      .rst    (rst),
      .clr    (accept),
      .en     (st == PH_ACC),
      .x      (rd_data),
      .c      (c_cos),
      .s      (c_sin),
      .acc_re (acc_re),
      .acc_im (acc_im)
   );

   phz_scale #(.ACC_W(ACC_W), .KW(KW), .K(KVAL), .SH(SH), .OW(OW), .SATURATE(SATURATE)) u_sc_re (
      .acc (acc_re),
      .y   (sc_re)
   );

   phz_scale #(.ACC_W(ACC_W), .KW(KW), .K(KVAL), .SH(SH), .OW(OW), .SATURATE(SATURATE)) u_sc_im (
      .acc (acc_im),
      .y   (sc_im)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st           <= PH_IDLE;
         tap          <= '0;
         rd_addr      <= '0;
         phasor_valid <= 1'b0;
         phasor_re    <= '0;
         phasor_im    <= '0;
         mark_overrun <= 1'b0;
      end else begin
         phasor_valid <= 1'b0;
         mark_overrun <= report_mark && (st != PH_IDLE);
         case (st)
            PH_IDLE: begin
               if (report_mark) begin
                  rd_addr <= base;
                  tap     <= '0;
                  st      <= PH_ACC;
               end
            end
            PH_ACC: begin
               rd_addr <= (rd_addr == AW'(N - 1)) ? '0 : rd_addr + 1'b1;
               tap     <= (tap == AW'(N - 1)) ? '0 : tap + 1'b1;
               if (tap == AW'(N - 1)) st <= PH_SCALE;
            end
            PH_SCALE: begin
               phasor_valid <= 1'b1;
               phasor_re    <= sc_re;
               phasor_im    <= sc_im;
               st           <= PH_IDLE;
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/phz_centered_dft_chk.sv
module phz_centered_dft_chk #(
   parameter int N  = 16,
   parameter int OW = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 report_mark,
   input logic                 phasor_valid,
   input logic signed [OW-1:0] phasor_re,
   input logic signed [OW-1:0] phasor_im,
   input logic                 mark_overrun
);

   int busy_cnt;

   always_ff @(posedge clk) begin
      if (rst)                busy_cnt <= 0;
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      else if (report_mark)   busy_cnt <= N + 1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!phasor_valid && !mark_overrun));

   p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
      (busy_cnt == 1) |=> phasor_valid);

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      phasor_valid |=> !phasor_valid);

   p_no_stray_valid_r11: assert property (@(posedge clk) disable iff (rst)
      (busy_cnt != 1) |=> !phasor_valid);

   p_overrun_flag_r8: assert property (@(posedge clk) disable iff (rst)
      (report_mark && busy_cnt != 0) |=> mark_overrun);

   p_no_stray_overrun_r8: assert property (@(posedge clk) disable iff (rst)
      !(report_mark && busy_cnt != 0) |=> !mark_overrun);

   p_output_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (busy_cnt != 1) |=> ($stable(phasor_re) && $stable(phasor_im)));

endmodule

bind phz_centered_dft phz_centered_dft_chk #(.N(N), .OW(OW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .report_mark  (report_mark),
   .phasor_valid (phasor_valid),
   .phasor_re    (phasor_re),
   .phasor_im    (phasor_im),
   .mark_overrun (mark_overrun)
);

// File: tb/tb_phz_centered_dft.sv
module tb_phz_centered_dft;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int  N    = 16;
   localparam int  KS   = 16 + 4;
   localparam int  SH   = 15 + KS;
   localparam real PI_R = 3.14159265358979323846;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              sample_valid;
   logic signed [15:0] sample_in;
   logic              report_mark;
   logic              phasor_valid;
   logic signed [15:0] phasor_re;
   logic signed [15:0] phasor_im;
   logic              mark_overrun;

   always #2.5 clk = ~clk;

   phz_centered_dft dut (
      .clk          (clk),
      .rst          (rst),
      .sample_valid (sample_valid),
      .sample_in    (sample_in),
      .report_mark  (report_mark),
      .phasor_valid (phasor_valid),
      .phasor_re    (phasor_re),
      .phasor_im    (phasor_im),
      .mark_overrun (mark_overrun)
   );

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;
   int  v_seen = 0;
   int  o_seen = 0;
   int  cap_re = 0;
   int  cap_im = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rnd(input real v);
      return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
   endfunction

   function automatic real ang(input int m);
      return 2.0 * PI_R * (real'(m) - real'(N) / 2.0 + 0.5) / real'(N);
   endfunction

   function automatic int fin(input longint a);
      longint k;
      longint y;
      k = longint'(rnd($sqrt(2.0) * (2.0 ** KS) / real'(N)));
      y = (a * k + (64'sd1 <<< (SH - 1))) >>> SH;
      if (y > 32767)  y = 32767;
      if (y < -32768) y = -32768;
      return int'(y);
   endfunction

   // behavioural reference model
   int hist[$];
   int cnt = 0;
   bit e_valid = 0;
   bit e_ovr = 0;
   int e_re = 0, e_im = 0, p_re = 0, p_im = 0, h_re = 0, h_im = 0;

   task automatic ref_phasor(output int ore, output int oim);
      longint ar = 0;
      longint ai = 0;
      for (int m = 0; m < N; m++) begin
         ar += longint'(hist[m]) * rnd(32767.0 * $cos(ang(m)));
         ai -= longint'(hist[m]) * rnd(32767.0 * $sin(ang(m)));
      end
      ore = fin(ar);
      oim = fin(ai);
   endtask

   always @(posedge clk) begin
      bit busy;
      if (rst) begin
         hist = {};
         for (int i = 0; i < N; i++) hist.push_back(0);
         cnt = 0; e_valid = 0; e_ovr = 0; h_re = 0; h_im = 0;
      end else begin
         busy = (cnt != 0);
         e_valid = 0;
         e_ovr = 0;
         if (cnt != 0) begin
            cnt--;
            if (cnt == 0) begin
               e_valid = 1; e_re = p_re; e_im = p_im; h_re = p_re; h_im = p_im;
            end
         end
         if (sample_valid) begin
            void'(hist.pop_front());
            hist.push_back(int'(sample_in));
         end
         if (report_mark) begin
            if (busy) e_ovr = 1;
            else begin
               ref_phasor(p_re, p_im);
               cnt = N + 1;
            end
         end
      end
   end

   task automatic step(input bit v, input int d, input bit mk);
      @(negedge clk);
      chk(phasor_valid == e_valid, "R2 valid timing", phasor_valid, e_valid);
      chk(mark_overrun == e_ovr, "R8 overrun flag", mark_overrun, e_ovr);
      if (e_valid) begin
         chk(int'(phasor_re) == e_re, "R4 R5 R6 real part", phasor_re, e_re);
         chk(int'(phasor_im) == e_im, "R4 R5 R6 imag part", phasor_im, e_im);
      end else begin
         chk(int'(phasor_re) == h_re, "R12 real hold", phasor_re, h_re);
         chk(int'(phasor_im) == h_im, "R12 imag hold", phasor_im, h_im);
      end
      if (phasor_valid) begin
         v_seen++; cap_re = int'(phasor_re); cap_im = int'(phasor_im);
      end
      if (mark_overrun) o_seen++;
      sample_valid = v;
      sample_in    = 16'(d);
      report_mark  = mk;
   endtask

   task automatic idle(input int n, input bit noise);
      for (int i = 0; i < n; i++) begin
         if (noise) step(1'b1, int'($urandom_range(65535)) - 32768, 1'b0);
         else       step(1'b0, 0, 1'b0);
      end
   endtask

   task automatic send_wave(input int a, input real phi);
      for (int m = 0; m < N; m++)
         step(1'b1, rnd(real'(a) * $cos(ang(m) + phi)), m == N - 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         chk(1'b0, "R2 watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int q_re;
      int q_im;
      int v0;
      int o0;
      sample_valid = 0; sample_in = 0; report_mark = 0;
      idle(4, 1'b0);
      // R1: reset state at the ports
      chk(phasor_valid == 0 && mark_overrun == 0, "R1 reset flags", {phasor_valid, mark_overrun}, 0);
      chk(phasor_re == 0 && phasor_im == 0, "R1 reset outputs", phasor_re, 0);
      rst = 1'b0;
      idle(2, 1'b0);
      chk(phasor_valid == 0 && mark_overrun == 0, "R1 after release", phasor_valid, 0);

      // R11: samples without marks give no phasor
      v0 = v_seen;
      idle(40, 1'b1);
      chk(v_seen == v0, "R11 no mark no valid", v_seen - v0, 0);

      // R7: nominal accuracy, phase 0 and phase 60 degrees
      send_wave(20000, 0.0);
      idle(N + 3, 1'b0);
      chk(cap_re >= 14138 && cap_re <= 14146, "R7 phase0 real", cap_re, 14142);
      chk(cap_im >= -4 && cap_im <= 4, "R7 phase0 imag", cap_im, 0);
      send_wave(20000, PI_R / 3.0);
      idle(N + 3, 1'b0);
      chk(cap_re >= 7067 && cap_re <= 7075, "R7 phase60 real", cap_re, 7071);
      chk(cap_im >= 12243 && cap_im <= 12251, "R7 phase60 imag", cap_im, 12247);

      // R9: same window, quiet versus streaming during computation
      send_wave(12000, 0.5);
      idle(N + 3, 1'b0);
      q_re = cap_re; q_im = cap_im;
      send_wave(12000, 0.5);
      idle(N + 3, 1'b1);
      chk(cap_re == q_re && cap_im == q_im, "R9 streaming unaffected", cap_re, q_re);

      // R3: full-scale windows
      for (int m = 0; m < N; m++) step(1'b1, -32768, m == N - 1);
      idle(N + 3, 1'b0);
      for (int m = 0; m < N; m++)
         step(1'b1, ($cos(ang(m)) >= 0.0) ? 32767 : -32768, m == N - 1);
      idle(N + 3, 1'b0);
      chk(cap_re > 29000, "R3 full scale no overflow", cap_re, 29000);

      // R8, R10: marks during busy are dropped, mark at N+2 accepted
      v0 = v_seen; o0 = o_seen;
      send_wave(15000, 1.0);
      for (int j = 1; j <= N + 2; j++)
         step(1'b1, int'($urandom_range(65535)) - 32768, (j == 3) || (j == N + 1) || (j == N + 2));
      idle(N + 4, 1'b0);
      chk(v_seen - v0 == 2, "R10 second mark accepted", v_seen - v0, 2);
      chk(o_seen - o0 == 2, "R8 two marks dropped", o_seen - o0, 2);

      // mixed random traffic
      for (int i = 0; i < 400; i++)
         step($urandom_range(3) != 0, int'($urandom_range(65535)) - 32768, $urandom_range(9) == 0);
      idle(N + 4, 1'b0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule